// File: doc/BRIEF.md
# Dual-Channel Sine-Fit Correlator

This block measures the in-phase and quadrature content of the two secondary-winding voltages of an inductive position transducer. Each accepted sample pair is multiplied by a cosine and a sine reference coefficient for the current sample position. The products are summed over a frame of selectable length. Because every frame length holds a whole number of reference periods, the four sums are least-squares sine-fit amplitude projections. A later stage turns them into amplitudes and a position ratio.

A start-of-frame pulse arms the block, sets the frame length and empties the accumulators. From then on, every cycle with `in_valid` high contributes one sample per channel. After the last sample of a frame, the four sums move to the output registers and `done` pulses. The next frame then begins with the next valid sample and keeps the same length. The coefficients sit in a one-period table of 100 entries. The table is computed at elaboration and indexed by the sample position modulo 100.

Top module: `sine_fit_corr`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `done` is low and `ac1`, `as1`, `ac2` and `as2` are zero.
- R2: `frame_sel` is sampled when `sof` is high and sets the frame length N: code 0 gives 2000, 1 gives 1500, 2 gives 1000, 3 gives 500, 4 gives 300 and 5 gives 100. Codes 6 and 7 give 2000.
- R3: The sample at position k of a frame (counting from 0) is weighted by C(m) = round(16777·cos(2πm/100)) for the cosine sum and by S(m) = round(16777·sin(2πm/100)) for the sine sum, with m = k mod 100. Rounding is to the nearest integer. The weights are Q-9.24 values and the samples are signed Q0.15, so `ac`=Σy·C and `as`=Σy·S in units of 2^-39.
- R4: Each sum is a 41-bit two's-complement value that holds the full-precision total with no truncation, including totals beyond the 32-bit range.
- R5: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the Nth sample of a frame. The four outputs take the new sums at that same edge.
- R6: A cycle with `in_valid` low adds nothing and does not advance the sample position, whatever `y1` and `y2` carry.
- R7: `sof` abandons the frame in progress. If `in_valid` is high in the same cycle, that sample becomes position 0 of the new frame. Otherwise the next valid sample becomes position 0.
- R8: If `sof` falls in the cycle that would have carried the Nth sample of the running frame, the restart wins. The old frame produces no `done`.
- R9: The four outputs do not change except at the edge that raises `done`.
- R10: After reset and before the first `sof`, valid samples are ignored and produce no `done`.
- R11: After a frame completes, the next valid sample starts a new frame of the same length at position 0. No new `sof` is needed.
- R12: The two channels are summed independently. Both use the same coefficient pair for a given position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; clears, arms and latches the length code |
| in_valid | input | 1 | A sample pair is present on `y1`/`y2` |
| frame_sel | input | 3 | Frame length code, sampled with `sof` |
| y1 | input | 16 | Channel 1 sample, signed Q0.15 |
| y2 | input | 16 | Channel 2 sample, signed Q0.15 |
| done | output | 1 | One-cycle strobe: new sums are on the outputs |
| ac1 | output | 41 | Channel 1 cosine sum |
| as1 | output | 41 | Channel 1 sine sum |
| ac2 | output | 41 | Channel 2 cosine sum |
| as2 | output | 41 | Channel 2 sine sum |

## Verification
Two of this block's functions can fall in the same cycle: a frame restart and the completion of a frame. The bench provokes this by sending 99 samples of a 100-sample frame, idling one cycle, and then raising `sof` together with a valid sample. That cycle is exactly where the 100th sample would have completed the frame. The scoreboard holds no entry for the abandoned frame, so any `done` there is reported. The sums delivered at the end of the following frame must treat the colliding sample as position 0. A second case raises `sof` without a sample partway through a frame and checks that nothing from before it leaks into the next result.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int NUM_CH = 2;   // secondary windings
  localparam int NUM_Q  = 2;   // 0: cosine, 1: sine
  localparam real TWO_PI = 6.283185307179586;

  // Frame length for a length code; unknown codes fall back to the longest frame.
  function automatic int frame_len(input logic [2:0] code);
    case (code)
      3'd0:    return 2000;
      3'd1:    return 1500;
      3'd2:    return 1000;
      3'd3:    return 500;
      3'd4:    return 300;
      3'd5:    return 100;
      default: return 2000;
    endcase
  endfunction

  // Reference weight for table position k of a period; quad selects the sine column.
  function automatic int ref_coef(input int k, input int period, input int amp, input bit quad);
    real ang;
    ang = TWO_PI * real'(k) / real'(period);
    if (quad) return int'(real'(amp) * $sin(ang));
    return int'(real'(amp) * $cos(ang));
  endfunction

endpackage

// File: rtl/sfc_ref_rom.sv
module sfc_ref_rom
  import sfc_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PERIOD = 100,
  parameter int AMP    = 16777,
  localparam int IDX_W = $clog2(PERIOD)
) (
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] coef [NUM_Q]
);

  logic signed [COEF_W-1:0] tab [NUM_Q][PERIOD];

  for (genvar q = 0; q < NUM_Q; q++) begin : g_col
    for (genvar k = 0; k < PERIOD; k++) begin : g_ent
      localparam int VAL = ref_coef(k, PERIOD, AMP, q == 1);
      assign tab[q][k] = COEF_W'(VAL);
    end
    assign coef[q] = (int'(idx) < PERIOD) ? tab[q][idx] : '0;
  end

endmodule

// File: rtl/sfc_frame_seq.sv
module sfc_frame_seq
  import sfc_pkg::*;
#(
  parameter int MAX_LEN = 2000,
  parameter int PERIOD  = 100,
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             in_valid,
  input  logic [2:0]       frame_sel,
  output logic             accept,
  output logic             clear,
  output logic             last,
  output logic [IDX_W-1:0] idx
);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [IDX_W-1:0] ph_q;
  logic [IDX_W-1:0] ph_inc;

  // A restart pulse carries its own sample as position 0.
  assign accept = in_valid && (armed_q || sof);
  assign clear  = sof;
  assign last   = accept && !sof && (cnt_q == len_q - 1'b1);
  assign idx    = sof ? '0 : ph_q;
  assign ph_inc = (int'(idx) == PERIOD - 1) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      ph_q    <= '0;
      len_q   <= CNT_W'(frame_len(3'd0));
    end else begin
      if (sof) begin
        armed_q <= 1'b1;
        len_q   <= CNT_W'(frame_len(frame_sel));
      end
      if (accept) begin
        if (last) begin
          cnt_q <= '0;
          ph_q  <= '0;
        end else begin
          cnt_q <= (sof ? '0 : cnt_q) + 1'b1;
          ph_q  <= ph_inc;
        end
      end else if (sof) begin
        cnt_q <= '0;
        ph_q  <= '0;
      end
    end
  end

  // R2: the position counter never reaches the latched frame length
  p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < len_q));

  // R10: while idle, samples do not move the position counter
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !sof) |=> (cnt_q == '0));

endmodule

// File: rtl/sfc_chan_acc.sv
module sfc_chan_acc
  import sfc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 41,
  localparam int PROD_W  = SAMPLE_W + COEF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [COEF_W-1:0]   coef [NUM_Q],
  input  logic                       accept,
  input  logic                       clear,
  input  logic                       last,
  output logic signed [ACC_W-1:0]    sum [NUM_Q]
);

  // Full-precision multiply-accumulate step.
  function automatic logic signed [ACC_W-1:0] mac(
    input logic signed [ACC_W-1:0]    base,
    input logic signed [SAMPLE_W-1:0] s,
    input logic signed [COEF_W-1:0]   c,
    input logic                       en
  );
    logic signed [PROD_W-1:0] p;
    p = s * c;
    return en ? base + ACC_W'(p) : base;
  endfunction

  for (genvar q = 0; q < NUM_Q; q++) begin : g_quad
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] sum_q;
    logic signed [ACC_W-1:0] nxt;

    assign nxt    = mac(clear ? '0 : acc_q, sample, coef[q], accept);
    assign sum[q] = sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        sum_q <= '0;
      end else if (last) begin
        sum_q <= nxt;
        acc_q <= '0;
      end else begin
        acc_q <= nxt;
      end
    end

    // R7: a restart without a sample leaves an empty accumulator
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !accept) |=> (acc_q == '0));
  end

endmodule

// File: rtl/sine_fit_corr.sv
module sine_fit_corr
  import sfc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 41,
  parameter int PERIOD   = 100,
  parameter int AMP      = 16777,
  parameter int MAX_LEN  = 2000,
  localparam int IDX_W   = $clog2(PERIOD)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sof,
  input  logic                       in_valid,
  input  logic [2:0]                 frame_sel,
  input  logic signed [SAMPLE_W-1:0] y1,
  input  logic signed [SAMPLE_W-1:0] y2,
  output logic                       done,
  output logic signed [ACC_W-1:0]    ac1,
  output logic signed [ACC_W-1:0]    as1,
  output logic signed [ACC_W-1:0]    ac2,
  output logic signed [ACC_W-1:0]    as2
);

  logic                       accept;
  logic                       clear;
  logic                       last;
  logic [IDX_W-1:0]           idx;
  logic signed [COEF_W-1:0]   coef   [NUM_Q];
  logic signed [SAMPLE_W-1:0] ch_in  [NUM_CH];
  logic signed [ACC_W-1:0]    ch_sum [NUM_CH][NUM_Q];
  logic                       done_q;

  sfc_frame_seq #(.MAX_LEN(MAX_LEN), .PERIOD(PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .frame_sel(frame_sel),
    .accept(accept), .clear(clear), .last(last), .idx(idx)
  );

  sfc_ref_rom #(.COEF_W(COEF_W), .PERIOD(PERIOD), .AMP(AMP)) u_rom (
    .idx(idx), .coef(coef)
  );

  assign ch_in[0] = y1;
  assign ch_in[1] = y2;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sfc_chan_acc #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .sample(ch_in[c]), .coef(coef),
      .accept(accept), .clear(clear), .last(last), .sum(ch_sum[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= last;
  end

  assign done = done_q;
  assign ac1  = ch_sum[0][0];
  assign as1  = ch_sum[0][1];
  assign ac2  = ch_sum[1][0];
  assign as2  = ch_sum[1][1];

  // R5: the strobe lasts one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: a strobe is always preceded by an accepted sample cycle
  p_done_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));

  // R8: a restart never completes the frame it abandons
  p_sof_blocks_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !done);

  // R9: results hold between strobes
  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ac1) && $stable(as1) && $stable(ac2) && $stable(as2)));

endmodule

// File: tb/sine_fit_corr_tb.sv
`timescale 1ns/1ps
module sine_fit_corr_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] frame_sel = 3'd0;
  logic signed [15:0] y1 = '0;
  logic signed [15:0] y2 = '0;
  logic done;
  logic signed [40:0] ac1, as1, ac2, as2;

  always #5 clk = ~clk;

  sine_fit_corr u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .frame_sel(frame_sel),
    .y1(y1), .y2(y2), .done(done), .ac1(ac1), .as1(as1), .ac2(ac2), .as2(as2)
  );

  typedef struct {
    longint c1;
    longint s1;
    longint c2;
    longint s2;
    string  tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int hold_err = 0;
  longint p1 = 0, p2 = 0, p3 = 0, p4 = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Reference weights computed from R3.
  function automatic longint wcos(input int m);
    return longint'(int'(16777.0 * $cos(6.283185307179586 * real'(m) / 100.0)));
  endfunction
  function automatic longint wsin(input int m);
    return longint'(int'(16777.0 * $sin(6.283185307179586 * real'(m) / 100.0)));
  endfunction

  function automatic int gen_y(input int ch, input int k, input int amp);
    real ph;
    ph = 6.283185307179586 * real'(k) / 100.0 + 0.3 + 1.1 * real'(ch);
    return int'(real'(amp) * $cos(ph)) + ((k * 7 + ch * 3) % 9) - 4;
  endfunction

  // Driver: plays one frame (or part of one) and queues the expected sums.
  task automatic run_frame(input int sel, input int n, input bit do_sof, input int gap,
                           input bit expect_done, input int amp, input string tag);
    longint e1 = 0, e2 = 0, e3 = 0, e4 = 0;
    for (int k = 0; k < n; k++) begin
      int a, b;
      if (gap > 0 && (k % gap) == gap - 1) begin
        @(negedge clk);
        sof = 1'b0; in_valid = 1'b0;
        y1 = 16'sh7fff; y2 = -16'sh7fff;   // R6: must be ignored
      end
      @(negedge clk);
      sof = do_sof && (k == 0);
      frame_sel = sel[2:0];
      in_valid = 1'b1;
      a = gen_y(0, k, amp);
      b = gen_y(1, k, amp);
      y1 = 16'(a);
      y2 = 16'(b);
      e1 += longint'(a) * wcos(k % 100);
      e2 += longint'(a) * wsin(k % 100);
      e3 += longint'(b) * wcos(k % 100);
      e4 += longint'(b) * wsin(k % 100);
      if (k == n - 1 && expect_done) exp_q.push_back('{e1, e2, e3, e4, tag});
    end
    @(negedge clk);
    sof = 1'b0; in_valid = 1'b0;
    if (expect_done) check(done == 1'b1, {"R5 strobe after last sample ", tag}, longint'(done), 1);
    else             check(done == 1'b0, {"R8 no strobe for partial frame ", tag}, longint'(done), 0);
  endtask

  // Monitor: pops the scoreboard on each strobe; watches R9 between strobes.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(longint'(ac1) == e.c1, {e.tag, " R3 ac1"}, longint'(ac1), e.c1);
          check(longint'(as1) == e.s1, {e.tag, " R3 as1"}, longint'(as1), e.s1);
          check(longint'(ac2) == e.c2, {e.tag, " R12 ac2"}, longint'(ac2), e.c2);
          check(longint'(as2) == e.s2, {e.tag, " R12 as2"}, longint'(as2), e.s2);
        end
      end else if (longint'(ac1) != p1 || longint'(as1) != p2 ||
                   longint'(ac2) != p3 || longint'(as2) != p4) begin
        hold_err++;
      end
      p1 = longint'(ac1); p2 = longint'(as1); p3 = longint'(ac2); p4 = longint'(as2);
    end
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", longint'(done), 0);
    check(ac1 == '0, "R1 ac1", longint'(ac1), 0);
    check(as1 == '0, "R1 as1", longint'(as1), 0);
    check(ac2 == '0, "R1 ac2", longint'(ac2), 0);
    check(as2 == '0, "R1 as2", longint'(as2), 0);

    // R10: samples before the first sof are ignored
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      in_valid = 1'b1; frame_sel = 3'd5;
      y1 = 16'(i * 211); y2 = 16'(-i * 97);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(ac1 == '0 && as1 == '0, "R10 sums idle ch1", longint'(ac1), 0);
    check(ac2 == '0 && as2 == '0, "R10 sums idle ch2", longint'(ac2), 0);

    run_frame(5, 100,  1'b1, 0, 1'b1, 20000, "R2 len100");
    run_frame(5, 100,  1'b0, 0, 1'b1, 15000, "R11 auto restart");
    run_frame(4, 300,  1'b1, 3, 1'b1, 25000, "R6 gaps len300");
    run_frame(3, 500,  1'b1, 0, 1'b1, 10000, "R2 len500");
    run_frame(2, 1000, 1'b1, 0, 1'b1, 30000, "R2 len1000");
    run_frame(1, 1500, 1'b1, 4, 1'b1, 5000,  "R2 R6 len1500");
    run_frame(0, 2000, 1'b1, 0, 1'b1, 32000, "R4 wide sums len2000");
    run_frame(7, 2000, 1'b1, 0, 1'b1, 12000, "R2 default code");

    // R7: restart without a sample discards the partial frame
    run_frame(5, 40, 1'b1, 0, 1'b0, 8000, "R7 partial");
    @(negedge clk);
    sof = 1'b1; in_valid = 1'b0; frame_sel = 3'd5;
    @(negedge clk);
    sof = 1'b0;
    run_frame(5, 100, 1'b0, 0, 1'b1, 18000, "R7 after clear");

    // R8: restart collides with the would-be final sample
    run_frame(5, 99,  1'b1, 0, 1'b0, 9000,  "R8 partial");
    run_frame(5, 100, 1'b1, 0, 1'b1, 22000, "R8 R7 collision");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 all strobes seen", longint'(exp_q.size()), 0);
    check(hold_err == 0, "R9 outputs held between strobes", longint'(hold_err), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule